// File: doc/BRIEF.md
# Configurable Reset and Watchdog Supervisor

This block generates the reset that holds a small microcontroller core. It has three sources: loss of power, a qualified dip in the supply and a watchdog timeout. A 14-bit configuration word turns three features on or off. An active-low bit enables a power-up delay. An active-high bit enables brown-out detection. Another active-high bit enables the watchdog. When the reset sources are quiet, the block steps through a fixed sequence before it lets the core run. First it waits for power. Then it runs the optional power-up delay, counted in slow timebase ticks. Last it runs an oscillator start-up count in core clock cycles.

A two-bit cause register records which source produced the most recent reset, and the core reads it after it is released. Every delay length is a parameter, so a simulation can use short counts and a product can use real ones. A running watchdog must receive a clear strobe before its window of slow ticks runs out. If it does not, the core is put back into reset and the whole start-up sequence runs again.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `core_hold` to 1 and `rst_cause` to the power-on code 2'b01. `rst_cause` never reads 2'b00 after reset.
- R2: If `pwr_good` is low at an edge, `core_hold` is 1 after that edge and `rst_cause` is 2'b01. When power returns, the start-up sequence runs again from its beginning.
- R3: When `cfg_word[3]` is 0, a power-up delay of `PWRT_TICKS` slow ticks runs first. It advances only on edges where `slow_tick` is 1.
- R4: After the power-up delay, or straight after leaving hold when the delay is skipped, the core stays in reset for a further `OST_CYCLES` clock cycles. With power good and ticks present on every cycle, release comes at edge `OST_CYCLES+1` (delay off) or edge `PWRT_TICKS+OST_CYCLES+1` (delay on), counted from the first edge with power good and reset high.
- R5: When `cfg_word[6]` is 1, the brown-out detector trips in two steps. First, `supply_low` must stay high over `BOR_TICKS` counted slow ticks. Then `supply_low` must still be high at a later edge. After the trip, `core_hold` is 1 and `rst_cause` is 2'b10, and the hold lasts until `supply_low` falls.
- R6: A dip that does not meet R5 has no effect. The qualification count restarts at zero whenever `supply_low` is low.
- R7: After recovery from a brown-out, the power-up delay of R3 always runs before the start-up count, whatever the value of `cfg_word[3]`.
- R8: When `cfg_word[6]` is 0, `supply_low` has no effect.
- R9: When `cfg_word[2]` is 1 and the core is released, `WDT_TICKS` slow ticks with no clear strobe put the core back in reset. `rst_cause` becomes 2'b11, and the sequence of R3 and R4 then runs again.
- R10: A `wdt_clear` pulse restarts the watchdog window, and a clear in the same cycle as the final tick prevents the timeout. When `cfg_word[2]` is 0, there is no watchdog reset.
- R11: The watchdog count is held at zero while the core is in reset, so every release grants a full window of `WDT_TICKS` ticks.
- R12: While the core is released, `rst_cause` does not change. When sources coincide, power loss beats brown-out, and brown-out beats the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset of the supervisor |
| cfg_word | input | 14 | Configuration word; bit 3 low enables power-up delay, bit 6 enables brown-out, bit 2 enables watchdog |
| pwr_good | input | 1 | High when the supply has reached operating level |
| supply_low | input | 1 | Supply-dip comparator flag |
| wdt_clear | input | 1 | Watchdog clear strobe from the core |
| slow_tick | input | 1 | One-cycle pulse of the free-running slow timebase |
| core_hold | output | 1 | High while the core is held in reset |
| rst_cause | output | 2 | Source of latest reset: 01 power-on, 10 brown-out, 11 watchdog |

## Verification
The assertions check several things on every cycle. Loss of power forces hold with the power-on cause. A released core stays released when the watchdog is off, when it is cleared, or when brown-out is disabled. The cause never changes during a run, and release only follows a cycle with good power. Only the bench scenarios can show the exact lengths of the delay chain and the one-tick edge of the dip filter. The same holds for the forced power-up delay after a brown-out and the full watchdog window after every release, because each depends on counting across many cycles.

// File: rtl/rst_sup_pkg.sv
// Shared types and configuration bit positions for the reset supervisor.
// Assumes a 14-bit configuration word; bit positions are fixed by the core.
package rst_sup_pkg;

    localparam int CFG_W      = 14;
    localparam int CFG_WDT_EN = 2;   // active high
    localparam int CFG_PWRT_N = 3;   // active low
    localparam int CFG_BOR_EN = 6;   // active high

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_POR  = 2'b01,
        CAUSE_BOR  = 2'b10,
        CAUSE_WDT  = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'b00,
        ST_PWRT = 2'b01,
        ST_OST  = 2'b10,
        ST_RUN  = 2'b11
    } seq_st_e;

endpackage

// File: rtl/rst_sup_bor_filter.sv
// Brown-out qualifier: counts slow ticks while the supply flag is high and
// trips once BOR_TICKS ticks have been seen and the flag is still high.
// Assumes slow_tick is a single-cycle pulse; count restarts on a good supply.
module rst_sup_bor_filter #(
    parameter int BOR_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic supply_low,
    input  logic slow_tick,
    output logic bor_low,
    output logic bor_trip
);

    localparam int CW = (BOR_TICKS < 1) ? 1 : $clog2(BOR_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(BOR_TICKS);

    logic [CW-1:0] dip_cnt;

    // Qualified low supply, seen only when detection is enabled.
    assign bor_low  = enable & supply_low;
    assign bor_trip = bor_low & (dip_cnt == FULL);

    // Count ticks of a continuous dip, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dip_cnt <= '0;
        end else if (!bor_low) begin
            dip_cnt <= '0;
        end else if (slow_tick && (dip_cnt != FULL)) begin
            dip_cnt <= dip_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/rst_sup_wdt.sv
// Watchdog window counter in slow ticks. Zero while the core is held,
// disabled or cleared; pulses expire on the tick that ends the window.
// Assumes WDT_TICKS >= 2 and a single-cycle slow_tick.
module rst_sup_wdt #(
    parameter int WDT_TICKS = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hold,
    input  logic clear,
    input  logic slow_tick,
    output logic expire
);

    localparam int CW = (WDT_TICKS < 2) ? 1 : $clog2(WDT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(WDT_TICKS - 1);

    logic [CW-1:0] win_cnt;

    // Final tick of an uncleared window while the core runs.
    assign expire = enable & ~hold & ~clear & slow_tick & (win_cnt == LAST);

    // Advance the window on each tick, restart on any blocking condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (hold || !enable || clear) begin
            win_cnt <= '0;
        end else if (slow_tick) begin
            win_cnt <= win_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/rst_sup_seq.sv
// Reset sequencer: hold, optional power-up delay (slow ticks), oscillator
// start-up count (clock cycles), run. Records the cause of each reset.
// Assumes the event inputs are already qualified; priority power > dip > watchdog.
module rst_sup_seq
    import rst_sup_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       bor_low,
    input  logic       bor_trip,
    input  logic       wdt_expire,
    input  logic       pwrt_en,
    input  logic       slow_tick,
    output logic       core_hold,
    output logic [1:0] cause_q
);

    localparam int SPAN = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int CW   = (SPAN < 2) ? 1 : $clog2(SPAN);
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
    localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);

    seq_st_e       st;
    logic [CW-1:0] cnt;
    logic          after_bor;

    assign core_hold = (st != ST_RUN);

    // State, shared delay counter and cause register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_HOLD;
            cnt       <= '0;
            after_bor <= 1'b0;
            cause_q   <= CAUSE_POR;
        end else if (!pwr_good) begin
            st        <= ST_HOLD;
            cnt       <= '0;
            after_bor <= 1'b0;
            cause_q   <= CAUSE_POR;
        end else if (bor_trip) begin
            st        <= ST_HOLD;
            cnt       <= '0;
            after_bor <= 1'b1;
            cause_q   <= CAUSE_BOR;
        end else if (wdt_expire) begin
            st        <= ST_HOLD;
            cnt       <= '0;
            cause_q   <= CAUSE_WDT;
        end else begin
            case (st)
                ST_HOLD: begin
                    cnt <= '0;
                    if (!bor_low) begin
                        st <= (pwrt_en || after_bor) ? ST_PWRT : ST_OST;
                    end
                end
                ST_PWRT: begin
                    if (slow_tick) begin
                        if (cnt == PWRT_LAST) begin
                            st        <= ST_OST;
                            cnt       <= '0;
                            after_bor <= 1'b0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_OST: begin
                    if (cnt == OST_LAST) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    st <= ST_RUN;
                end
            endcase
        end
    end

endmodule

// File: rtl/rst_supervisor.sv
// Top of the reset supervisor: decodes the configuration word and joins
// the brown-out filter, the watchdog and the sequencer.
// Assumes all inputs are synchronous to clk.
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024,
    parameter int BOR_TICKS  = 4,
    parameter int WDT_TICKS  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             pwr_good,
    input  logic             supply_low,
    input  logic             wdt_clear,
    input  logic             slow_tick,
    output logic             core_hold,
    output logic [1:0]       rst_cause
);

    logic pwrt_en, bor_en, wdt_en;
    logic bor_low, bor_trip, wdt_expire;
    logic cfg_spare_unused;

    // Decode the three feature bits; the rest belong to other blocks.
    assign pwrt_en          = ~cfg_word[CFG_PWRT_N];
    assign bor_en           = cfg_word[CFG_BOR_EN];
    assign wdt_en           = cfg_word[CFG_WDT_EN];
    assign cfg_spare_unused = ^{cfg_word[13:7], cfg_word[5:4], cfg_word[1:0]};

    rst_sup_bor_filter #(.BOR_TICKS(BOR_TICKS)) u_bor (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (bor_en),
        .supply_low (supply_low),
        .slow_tick  (slow_tick),
        .bor_low    (bor_low),
        .bor_trip   (bor_trip)
    );

    rst_sup_wdt #(.WDT_TICKS(WDT_TICKS)) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (wdt_en),
        .hold      (core_hold),
        .clear     (wdt_clear),
        .slow_tick (slow_tick),
        .expire    (wdt_expire)
    );

    rst_sup_seq #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .bor_low    (bor_low),
        .bor_trip   (bor_trip),
        .wdt_expire (wdt_expire),
        .pwrt_en    (pwrt_en),
        .slow_tick  (slow_tick),
        .core_hold  (core_hold),
        .cause_q    (rst_cause)
    );

endmodule

// File: rtl/rst_supervisor_chk.sv
// Port-level properties of the reset supervisor, bound to its top module.
// Assumes the configuration bit positions of rst_sup_pkg.
module rst_supervisor_chk
    import rst_sup_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_word,
    input logic             pwr_good,
    input logic             supply_low,
    input logic             wdt_clear,
    input logic             core_hold,
    input logic [1:0]       rst_cause
);

    p_cause_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cause != CAUSE_NONE);

    p_nopower_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (core_hold && rst_cause == CAUSE_POR));

    p_release_needs_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> $past(pwr_good));

    p_bor_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !core_hold && !cfg_word[CFG_BOR_EN]
         && (wdt_clear || !cfg_word[CFG_WDT_EN])) |=> !core_hold);

    p_wdt_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !core_hold && !cfg_word[CFG_WDT_EN] && !supply_low) |=> !core_hold);

    p_clear_keeps_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !core_hold && wdt_clear && !supply_low) |=> !core_hold);

    p_cause_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold |=> (core_hold || $stable(rst_cause)));

endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg_word),
    .pwr_good   (pwr_good),
    .supply_low (supply_low),
    .wdt_clear  (wdt_clear),
    .core_hold  (core_hold),
    .rst_cause  (rst_cause)
);

// File: tb/rst_supervisor_tb.sv
// Self-checking bench: sweeps all feature-bit combinations, then exercises
// tick gating, watchdog clearing, brown-out filtering and source priority.
module rst_supervisor_tb;

    localparam int P = 5;
    localparam int O = 16;
    localparam int B = 3;
    localparam int W = 6;

    logic        clk        = 1'b0;
    logic        rst_n      = 1'b0;
    logic [13:0] cfg        = 14'h3FFF;
    logic        pwr_good   = 1'b1;
    logic        supply_low = 1'b0;
    logic        wdt_clear  = 1'b0;
    logic        slow_tick  = 1'b1;
    logic        core_hold;
    logic [1:0]  rst_cause;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rst_supervisor #(
        .PWRT_TICKS(P), .OST_CYCLES(O), .BOR_TICKS(B), .WDT_TICKS(W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .pwr_good(pwr_good),
        .supply_low(supply_low), .wdt_clear(wdt_clear), .slow_tick(slow_tick),
        .core_hold(core_hold), .rst_cause(rst_cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply_reset(input logic [13:0] c);
        cfg = c; rst_n = 1'b0; pwr_good = 1'b1; supply_low = 1'b0;
        wdt_clear = 1'b0; slow_tick = 1'b1;
        repeat (3) step();
    endtask

    task automatic count_hold(output int n, input int limit);
        n = 0;
        while (core_hold && n < limit) begin step(); n++; end
    endtask

    task automatic count_run(output int n, input int limit);
        n = 0;
        while (!core_hold && n < limit) begin step(); n++; end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int n;
        int hits;
        logic [13:0] c;
        repeat (2) step();
        chk("R1 hold in reset", core_hold, 1);
        chk("R1 cause in reset", rst_cause, 1);

        // Sweep: bit0 -> delay on (cfg[3]=0), bit1 -> cfg[6], bit2 -> cfg[2]
        for (int k = 0; k < 8; k++) begin
            c = 14'h3FFF;
            c[3] = ~k[0];
            c[6] = k[1];
            c[2] = k[2];
            apply_reset(c);
            rst_n = 1'b1;
            count_hold(n, 200);
            chk("R3 R4 release latency", n, (k[0] ? P : 0) + O + 1);
            chk("R12 cause after power-on", rst_cause, 1);
            count_run(n, 3 * W);
            chk("R9 R10 watchdog window", n, k[2] ? W : 3 * W);
            if (k[2]) begin
                chk("R9 watchdog cause", rst_cause, 3);
                count_hold(n, 200);
                chk("R9 sequence reruns", n, (k[0] ? P : 0) + O + 1);
                count_run(n, 3 * W);
                chk("R11 full window after release", n, W);
            end
        end

        // R3: delay advances only on slow ticks
        apply_reset(14'h3FF3);
        slow_tick = 1'b0;
        rst_n = 1'b1;
        count_hold(n, 3 * (P + O));
        chk("R3 no ticks keeps hold", n, 3 * (P + O));
        slow_tick = 1'b1;
        count_hold(n, 200);
        chk("R3 ticks resume", n, P + O);

        // R10: periodic clear keeps the core running
        apply_reset(14'h3FFF);
        rst_n = 1'b1;
        count_hold(n, 200);
        hits = 0;
        for (int i = 0; i < 4 * W; i++) begin
            wdt_clear = ((i % (W - 2)) == (W - 3));
            step();
            if (core_hold) hits++;
        end
        wdt_clear = 1'b0;
        chk("R10 cleared watchdog no reset", hits, 0);
        count_run(n, 3 * W);
        chk("R10 window restarts at clear", n, W);

        // Brown-out filtering with watchdog off, delay off
        apply_reset(14'h3FFB);
        rst_n = 1'b1;
        count_hold(n, 200);
        supply_low = 1'b1; repeat (B) step();
        supply_low = 1'b0; step();
        supply_low = 1'b1; repeat (B) step();
        supply_low = 1'b0; repeat (3) step();
        chk("R6 short dips ignored", core_hold, 0);
        supply_low = 1'b1;
        repeat (B + 1) step();
        chk("R5 long dip trips", core_hold, 1);
        chk("R5 brown-out cause", rst_cause, 2);
        repeat (10) step();
        chk("R5 held while supply low", core_hold, 1);
        supply_low = 1'b0;
        count_hold(n, 200);
        chk("R7 delay forced after dip", n, P + O + 1);
        repeat (5) step();
        chk("R12 cause steady while running", rst_cause, 2);

        // R8: detection disabled
        apply_reset(14'h3FBB);
        rst_n = 1'b1;
        count_hold(n, 200);
        supply_low = 1'b1;
        repeat (4 * B) step();
        chk("R8 dip ignored when disabled", core_hold, 0);
        supply_low = 1'b0;

        // R2 and R12: power loss beats brown-out
        apply_reset(14'h3FFB);
        rst_n = 1'b1;
        count_hold(n, 200);
        pwr_good = 1'b0; supply_low = 1'b1;
        step();
        chk("R2 power loss holds", core_hold, 1);
        chk("R2 power loss cause", rst_cause, 1);
        repeat (2 * B) step();
        chk("R12 power beats brown-out", rst_cause, 1);
        pwr_good = 1'b1; supply_low = 1'b0;
        count_hold(n, 200);
        chk("R2 restart after power returns", n, O + 1);

        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1-all: got 0 expected 1 (run did not finish)");
        finish_run();
    end

endmodule